// File: doc/BRIEF.md
# Accumulator Unit

This block holds a single working register, the accumulator, and a one-bit link flag next to it. In each cycle it takes one update, picked from a set of decoded one-hot strobes. The strobes are built upstream from the opcode, the timing step and the register-reference bits. The block can combine the accumulator with a data operand by bitwise AND or by addition, copy the operand across, pull a narrow input word into its low bits, invert itself, rotate one place either way through the link flag, count up by one, or clear.

The operand and the input word arrive on plain data ports. Fetch, sequencing and memory are handled elsewhere. The surrounding controller reads the accumulator and link values from the two output ports.

When a faulty controller raises more than one strobe in the same cycle, a fixed priority settles the result, so the outcome is always defined. Widths are parameters: the accumulator is `DATA_W` bits (default 16) and the input word is `IN_W` bits (default 8).

Top module: `acc_logic_unit`

## Requirements
- R1: While `rstN` is low, and in the first cycle after it rises, `accOut` is all zeros and `linkOut` is 0.
- R2: With `opAnd` winning, the accumulator becomes the bitwise AND of its old value and `drIn`, one clock after the strobe.
- R3: With `opAdd` winning, the accumulator becomes the low `DATA_W` bits of old value plus `drIn`, and the link takes the carry out of the top bit.
- R4: With `opXfer` winning, the accumulator becomes `drIn`.
- R5: With `opInp` winning, accumulator bits `IN_W-1..0` take `inIn`, and bits `DATA_W-1..IN_W` keep their old value.
- R6: With `opCom` winning, the accumulator becomes the bitwise complement of its old value.
- R7: With `opShr` winning, the accumulator rotates right through the link: the old link enters bit `DATA_W-1`, and the old bit 0 goes to the link.
- R8: With `opShl` winning, the accumulator rotates left through the link: the old link enters bit 0, and the old bit `DATA_W-1` goes to the link.
- R9: With `opInc` winning, the accumulator becomes the old value plus one modulo 2^`DATA_W`. All ones wraps to zero, and the link does not change.
- R10: `opClr` forces the accumulator to zero and leaves the link unchanged.
- R11: When several strobes are high at once, exactly one takes effect, in this order from highest: `opClr`, `opAnd`, `opAdd`, `opXfer`, `opInp`, `opCom`, `opShr`, `opShl`, `opInc`.
- R12: The link changes only when add or a rotate wins. With no strobe high, both outputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| opAnd | input | 1 | AND operand into accumulator |
| opAdd | input | 1 | Add operand, carry to link |
| opXfer | input | 1 | Copy operand into accumulator |
| opInp | input | 1 | Load input word into low bits |
| opCom | input | 1 | Complement accumulator |
| opShr | input | 1 | Rotate right through link |
| opShl | input | 1 | Rotate left through link |
| opInc | input | 1 | Increment accumulator |
| opClr | input | 1 | Clear accumulator |
| drIn | input | DATA_W | Data operand |
| inIn | input | IN_W | Narrow input word |
| accOut | output | DATA_W | Accumulator value |
| linkOut | output | 1 | Link flag value |

## Verification
The bench runs the unit at an 8-bit accumulator with a 4-bit input word, and sweeps every strobe combination against an arithmetic model.

It targets the carry out of an all-ones sum. A design that dropped the carry would leave the link at its old value. It also targets increment wrap, where a faulty design would carry into the link. For the input load, a design that cleared the upper bits would lose them.

Rotates are checked with both link values. Getting the fill or exit bit wrong would break the nine-step cycle that returns the value to itself. A priority error would show up as the wrong source winning, or as a clear that still disturbs the link.

// File: rtl/acc_pkg.sv
package acc_pkg;

  // Source chosen for a full accumulator load
  typedef enum logic [2:0] {
    SRC_AND  = 3'd0,
    SRC_ADD  = 3'd1,
    SRC_XFER = 3'd2,
    SRC_INP  = 3'd3,
    SRC_COM  = 3'd4,
    SRC_SHR  = 3'd5,
    SRC_SHL  = 3'd6
  } accSrc_e;

  // Strobes from control to datapath; at most one of clr/ld/inc is set
  typedef struct packed {
    logic    clrAcc;
    logic    ldAcc;
    logic    incAcc;
    logic    ldLink;
    accSrc_e src;
  } accStrobe_t;

endpackage

// File: rtl/acc_ripple_adder.sv
module acc_ripple_adder #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] sum,
  output logic         carryOut
);

  logic [W:0] carry;

  assign carry[0] = 1'b0;

  // One full-adder cell per bit position
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign sum[i]     = a[i] ^ b[i] ^ carry[i];
    assign carry[i+1] = (a[i] & b[i]) | (carry[i] & (a[i] ^ b[i]));
  end

  assign carryOut = carry[W];

endmodule

// File: rtl/acc_ctrl.sv
module acc_ctrl
  import acc_pkg::*;
(
  input  logic       opAnd,
  input  logic       opAdd,
  input  logic       opXfer,
  input  logic       opInp,
  input  logic       opCom,
  input  logic       opShr,
  input  logic       opShl,
  input  logic       opInc,
  input  logic       opClr,
  output accStrobe_t strobe
);

  logic anyLoad;

  assign anyLoad = opAnd | opAdd | opXfer | opInp | opCom | opShr | opShl;

  always_comb begin
    strobe        = '0;
    strobe.src    = SRC_AND;

    if (opClr) begin
      strobe.clrAcc = 1'b1;
    end else if (anyLoad) begin
      strobe.ldAcc = 1'b1;
      // Fixed ranking among load sources
      if (opAnd)       strobe.src = SRC_AND;
      else if (opAdd)  strobe.src = SRC_ADD;
      else if (opXfer) strobe.src = SRC_XFER;
      else if (opInp)  strobe.src = SRC_INP;
      else if (opCom)  strobe.src = SRC_COM;
      else if (opShr)  strobe.src = SRC_SHR;
      else             strobe.src = SRC_SHL;
    end else if (opInc) begin
      strobe.incAcc = 1'b1;
    end

    // Link moves only with add or a rotate
    strobe.ldLink = strobe.ldAcc &&
                    (strobe.src == SRC_ADD || strobe.src == SRC_SHR ||
                     strobe.src == SRC_SHL);
  end

endmodule

// File: rtl/acc_datapath.sv
module acc_datapath
  import acc_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int IN_W   = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  accStrobe_t        strobe,
  input  logic [DATA_W-1:0] drIn,
  input  logic [IN_W-1:0]   inIn,
  output logic [DATA_W-1:0] accOut,
  output logic              linkOut
);

  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] accQ;
  logic              linkQ;
  logic [DATA_W-1:0] sumVal;
  logic              sumCarry;
  logic [DATA_W-1:0] loadVal;
  logic              linkNext;
  logic [DATA_W-1:0] incVal;

  acc_ripple_adder #(.W(DATA_W)) u_adder (
    .a        (accQ),
    .b        (drIn),
    .sum      (sumVal),
    .carryOut (sumCarry)
  );

  assign incVal = accQ + DATA_W'(1);

  always_comb begin
    loadVal  = accQ;
    linkNext = linkQ;
    unique case (strobe.src)
      SRC_AND:  loadVal = accQ & drIn;
      SRC_ADD:  begin
        loadVal  = sumVal;
        linkNext = sumCarry;
      end
      SRC_XFER: loadVal = drIn;
      SRC_INP:  loadVal = {accQ[MSB:IN_W], inIn};
      SRC_COM:  loadVal = ~accQ;
      SRC_SHR:  begin
        loadVal  = {linkQ, accQ[MSB:1]};
        linkNext = accQ[0];
      end
      SRC_SHL:  begin
        loadVal  = {accQ[MSB-1:0], linkQ};
        linkNext = accQ[MSB];
      end
      default:  loadVal = accQ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accQ  <= '0;
      linkQ <= 1'b0;
    end else begin
      if (strobe.clrAcc)      accQ <= '0;
      else if (strobe.ldAcc)  accQ <= loadVal;
      else if (strobe.incAcc) accQ <= incVal;
      if (strobe.ldLink)      linkQ <= linkNext;
    end
  end

  assign accOut  = accQ;
  assign linkOut = linkQ;

endmodule

// File: rtl/acc_logic_unit.sv
module acc_logic_unit
  import acc_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int IN_W   = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opAnd,
  input  logic              opAdd,
  input  logic              opXfer,
  input  logic              opInp,
  input  logic              opCom,
  input  logic              opShr,
  input  logic              opShl,
  input  logic              opInc,
  input  logic              opClr,
  input  logic [DATA_W-1:0] drIn,
  input  logic [IN_W-1:0]   inIn,
  output logic [DATA_W-1:0] accOut,
  output logic              linkOut
);

  accStrobe_t strobe;

  acc_ctrl u_ctrl (
    .opAnd  (opAnd),
    .opAdd  (opAdd),
    .opXfer (opXfer),
    .opInp  (opInp),
    .opCom  (opCom),
    .opShr  (opShr),
    .opShl  (opShl),
    .opInc  (opInc),
    .opClr  (opClr),
    .strobe (strobe)
  );

  acc_datapath #(.DATA_W(DATA_W), .IN_W(IN_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .drIn    (drIn),
    .inIn    (inIn),
    .accOut  (accOut),
    .linkOut (linkOut)
  );

endmodule

// File: rtl/acc_logic_checker.sv
module acc_logic_checker #(
  parameter int DATA_W = 16,
  parameter int IN_W   = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              opAnd,
  input logic              opAdd,
  input logic              opXfer,
  input logic              opInp,
  input logic              opCom,
  input logic              opShr,
  input logic              opShl,
  input logic              opInc,
  input logic              opClr,
  input logic [DATA_W-1:0] drIn,
  input logic [IN_W-1:0]   inIn,
  input logic [DATA_W-1:0] accOut,
  input logic              linkOut
);

  logic anyLoad;
  logic noStrobe;

  assign anyLoad  = opAnd | opAdd | opXfer | opInp | opCom | opShr | opShl;
  assign noStrobe = !anyLoad && !opInc && !opClr;

  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rstN)
    opClr |=> accOut == '0); // R10

  AST_LINK_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (opClr || !(opAdd || opShr || opShl)) |=> $stable(linkOut)); // R12

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    noStrobe |=> $stable(accOut)); // R12

  AST_XFER_COPY: assert property (@(posedge clk) disable iff (!rstN)
    (opXfer && !opClr && !opAnd && !opAdd) |=> accOut == $past(drIn)); // R4

  AST_INP_UPPER_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    (opInp && !opClr && !opAnd && !opAdd && !opXfer) |=>
      (accOut[DATA_W-1:IN_W] == $past(accOut[DATA_W-1:IN_W]) &&
       accOut[IN_W-1:0] == $past(inIn))); // R5

  AST_COM_FLIP: assert property (@(posedge clk) disable iff (!rstN)
    (opCom && !opClr && !opAnd && !opAdd && !opXfer && !opInp) |=>
      accOut == ~$past(accOut)); // R6

  AST_INC_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (opInc && !opClr && !anyLoad) |=>
      accOut == $past(accOut) + DATA_W'(1)); // R9

endmodule

bind acc_logic_unit acc_logic_checker #(.DATA_W(DATA_W), .IN_W(IN_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .opAnd   (opAnd),
  .opAdd   (opAdd),
  .opXfer  (opXfer),
  .opInp   (opInp),
  .opCom   (opCom),
  .opShr   (opShr),
  .opShl   (opShl),
  .opInc   (opInc),
  .opClr   (opClr),
  .drIn    (drIn),
  .inIn    (inIn),
  .accOut  (accOut),
  .linkOut (linkOut)
);

// File: tb/acc_logic_unit_tb.sv
`timescale 1ns/1ps
module acc_logic_unit_tb;

  localparam int TW  = 8;
  localparam int TIW = 4;

  // Strobe bit positions in the bench op vector
  localparam int B_AND = 0, B_ADD = 1, B_XFER = 2, B_INP = 3, B_COM = 4;
  localparam int B_SHR = 5, B_SHL = 6, B_INC = 7, B_CLR = 8;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic [8:0]     ops = '0;
  logic [TW-1:0]  drIn = '0;
  logic [TIW-1:0] inIn = '0;
  logic [TW-1:0]  accOut;
  logic           linkOut;

  logic [TW-1:0]  expAcc = '0;
  logic           expLink = 1'b0;
  int             total = 0;
  int             bad = 0;
  bit             finished = 0;

  always #2 clk = ~clk;

  acc_logic_unit #(.DATA_W(TW), .IN_W(TIW)) u_dut (
    .clk     (clk),
    .rstN    (rstN),
    .opAnd   (ops[B_AND]),
    .opAdd   (ops[B_ADD]),
    .opXfer  (ops[B_XFER]),
    .opInp   (ops[B_INP]),
    .opCom   (ops[B_COM]),
    .opShr   (ops[B_SHR]),
    .opShl   (ops[B_SHL]),
    .opInc   (ops[B_INC]),
    .opClr   (ops[B_CLR]),
    .drIn    (drIn),
    .inIn    (inIn),
    .accOut  (accOut),
    .linkOut (linkOut)
  );

  // Arithmetic model built from the requirements; returns {link, acc}
  function automatic logic [TW:0] model(logic [TW-1:0] a, logic e, logic [8:0] o,
                                        logic [TW-1:0] d, logic [TIW-1:0] n);
    logic [TW:0] s;
    if (o[B_CLR])       return {e, {TW{1'b0}}};
    else if (o[B_AND])  return {e, a & d};
    else if (o[B_ADD])  begin s = {1'b0, a} + {1'b0, d}; return s; end
    else if (o[B_XFER]) return {e, d};
    else if (o[B_INP])  return {e, a[TW-1:TIW], n};
    else if (o[B_COM])  return {e, ~a};
    else if (o[B_SHR])  return {a[0], e, a[TW-1:1]};
    else if (o[B_SHL])  return {a[TW-1], a[TW-2:0], e};
    else if (o[B_INC])  return {e, a + TW'(1)};
    return {e, a};
  endfunction

  task automatic check(string req, logic [TW-1:0] gotA, logic gotE,
                       logic [TW-1:0] wantA, logic wantE);
    total++;
    if (gotA !== wantA || gotE !== wantE) begin
      bad++;
      $display("FAIL %s: acc=%h link=%b expected acc=%h link=%b",
               req, gotA, gotE, wantA, wantE);
    end
  endtask

  task automatic doOp(string req, logic [8:0] o, logic [TW-1:0] d, logic [TIW-1:0] n);
    logic [TW:0] nxt;
    @(negedge clk);
    ops  = o;
    drIn = d;
    inIn = n;
    nxt  = model(expAcc, expLink, o, d, n);
    @(posedge clk);
    #1;
    expAcc  = nxt[TW-1:0];
    expLink = nxt[TW];
    check(req, accOut, linkOut, expAcc, expLink);
    ops = '0;
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: run did not complete");
    finish();
  end

  initial begin
    // R1: reset state, during reset and right after release
    repeat (3) @(posedge clk);
    #1;
    check("R1", accOut, linkOut, '0, 1'b0);
    @(negedge clk);
    rstN = 1'b1;
    @(posedge clk);
    #1;
    check("R1", accOut, linkOut, '0, 1'b0);

    // R4: transfer every operand value
    for (int v = 0; v < 256; v++) doOp("R4", 9'(1 << B_XFER), TW'(v), '0);

    // R3: add with carry into link, including all-ones sums
    for (int a = 0; a < 256; a++) begin
      for (int j = 0; j < 37; j++) begin
        doOp("R3", 9'(1 << B_XFER), TW'(a), '0);
        doOp("R3", 9'(1 << B_ADD), TW'((j * 7 + 1) % 256), '0);
      end
    end
    doOp("R3", 9'(1 << B_XFER), 8'hFF, '0);
    doOp("R3", 9'(1 << B_ADD), 8'hFF, '0);

    // R2: AND
    for (int a = 0; a < 256; a += 3) begin
      for (int b = 0; b < 256; b += 5) begin
        doOp("R2", 9'(1 << B_XFER), TW'(a), '0);
        doOp("R2", 9'(1 << B_AND), TW'(b), '0);
      end
    end

    // R5: input load keeps the upper bits
    for (int a = 0; a < 256; a += 17) begin
      for (int n = 0; n < 16; n++) begin
        doOp("R5", 9'(1 << B_XFER), TW'(a), '0);
        doOp("R5", 9'(1 << B_INP), 8'h5A, TIW'(n));
      end
    end

    // R6: complement every value
    for (int a = 0; a < 256; a++) begin
      doOp("R6", 9'(1 << B_XFER), TW'(a), '0);
      doOp("R6", 9'(1 << B_COM), '0, '0);
    end

    // R7, R8: rotates with both link values
    for (int a = 0; a < 256; a++) begin
      doOp("R7", 9'(1 << B_XFER), TW'(a), '0);
      doOp("R7", 9'(1 << B_SHR), '0, '0);
      doOp("R8", 9'(1 << B_SHL), '0, '0);
      doOp("R8", 9'(1 << B_SHL), '0, '0);
    end
    // nine right rotates restore value and link
    doOp("R7", 9'(1 << B_XFER), 8'h96, '0);
    for (int k = 0; k < TW + 1; k++) doOp("R7", 9'(1 << B_SHR), '0, '0);
    check("R7", accOut, linkOut, 8'h96, expLink);

    // R9: increment including wrap; link untouched
    for (int a = 0; a < 256; a++) begin
      doOp("R9", 9'(1 << B_XFER), TW'(a), '0);
      doOp("R9", 9'(1 << B_INC), '0, '0);
    end

    // R10: clear from various values, link untouched
    for (int a = 0; a < 256; a += 15) begin
      doOp("R10", 9'(1 << B_XFER), TW'(a), '0);
      doOp("R10", 9'(1 << B_CLR), '0, '0);
    end

    // R11, R12: every strobe combination, including idle
    for (int m = 0; m < 512; m++) begin
      doOp("R11", 9'(1 << B_XFER), TW'(m * 37 + 11), '0);
      doOp("R11", 9'(m), TW'(m * 13 + 200), TIW'(m));
      doOp("R12", '0, 8'hC3, 4'h9);
    end

    finish();
  end

endmodule